// File: doc/BRIEF.md
# Strobe-Handshake FIFO with Ready Flags

This block is a small first-in first-out store, 64 words of 4 bits by default. It has no enable or full/empty ports. Each side runs a four-phase exchange of a strobe and a ready flag instead. The writer raises a shift-in strobe while the input-ready flag is high, and the flag drops. The flag comes back only once the strobe has been released and space remains. The reader does the same thing with a shift-out strobe and the output-ready flag.

All inputs are sampled on one system clock. The strobes act on the edges that this sampling sees.

A stored word does not appear at the output at once. It takes a fixed, configurable bubble-through latency to get there. The output register reads zero from reset until the first word arrives.

A master clear input empties the buffer. An output-enable input controls a separate drive-enable flag, which stands in for a tri-state output. When the buffer is full and the writer keeps its strobe high, the pending word is taken as soon as a read frees a location. This shows up as a one-cycle pulse of the input-ready flag.

Top module: `strobe_fifo`

## Requirements
- R1: When `si_i` rises while `ir_o` is high, `ir_o` is low in the next cycle. It stays low while `si_i` stays high. After `si_i` is sampled low, `ir_o` goes high again one cycle later if fewer than DEPTH words are stored.
- R2: When `so_i` rises while `or_o` is high, `or_o` is low in the next cycle. `or_o` stays low for every cycle in which `so_i` is high. It rises again only after `so_i` is low and another word is visible.
- R3: A word is stored only on a sampled rising edge of `si_i` while `ir_o` is high. A strobe raised while the buffer is full and released before any space frees stores nothing.
- R4: Words leave in the order they were accepted. `dout_o` changes only in the cycle that `or_o` rises, or on a clear. It holds its value while `so_i` is high after a read.
- R5: A clear sampled from `mr_i` discards all stored words. In the next cycle it gives `ir_o` = 1, `or_o` = 0 and `dout_o` = 0.
- R6: After reset or a clear, `dout_o` reads zero until the first written word reaches the output. A rising edge of `so_i` while `or_o` is low removes nothing and changes no output.
- R7: A word written into an empty buffer at clock edge E makes `or_o` rise after edge E + BT_CYCLES + 1.
- R8: Suppose the buffer is full and `si_i` is held high. Then a read that frees a location makes `ir_o` high for exactly one cycle, and the held word is captured at the end of that cycle.
- R9: `dout_en_o` is the inverse of `oe_i` sampled one clock earlier (1 = drive the data, 0 = high impedance).
- R10: After DEPTH accepted words with no read, `ir_o` stays low after `si_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_i | input | 1 | Master clear, synchronous, active high |
| si_i | input | 1 | Shift-in strobe |
| din_i | input | WIDTH | Write data, captured when a write is accepted |
| ir_o | output | 1 | Input-ready flag |
| so_i | input | 1 | Shift-out strobe |
| or_o | output | 1 | Output-ready flag; `dout_o` is valid while high |
| dout_o | output | WIDTH | Output data register |
| oe_i | input | 1 | Output disable request (1 = high impedance) |
| dout_en_o | output | 1 | Drive enable for `dout_o` |

## Verification
The hardest case to reach is the held write against a full buffer. Every location must be occupied and a strobe kept high. Then a single read must free exactly one slot, so that the one-cycle input-ready pulse and the late capture can be observed.

The stimulus first fills all DEPTH entries through normal handshakes. It then raises and drops a strobe that must be discarded. Next it raises a second strobe and holds it, and performs one read, checking `ir_o` in the two cycles that follow. A full drain then shows through the scoreboard that the discarded word is absent and the held word sits last.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    typedef enum logic {
        WR_OPEN = 1'b0,
        WR_HOLD = 1'b1
    } wr_phase_e;

    typedef enum logic {
        RD_OPEN = 1'b0,
        RD_HOLD = 1'b1
    } rd_phase_e;

    typedef struct packed {
        logic level;
        logic rise;
    } strobe_ev_t;

    function automatic int unsigned addr_bits(int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
    import strobe_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       strobe,
    output strobe_ev_t ev
);
    logic prev;

    always_ff @(posedge clk) begin
        if (clr) prev <= 1'b0;
        else     prev <= strobe;
    end

    always_comb begin
        ev.level = strobe;
        ev.rise  = strobe & ~prev;
    end
endmodule

// File: rtl/bubble_delay.sv
module bubble_delay #(
    parameter int unsigned STAGES = 3
) (
    input  logic clk,
    input  logic clr,
    input  logic pulse_in,
    output logic pulse_out
);
    generate
        if (STAGES == 0) begin : g_direct
            assign pulse_out = pulse_in;
        end else begin : g_pipe
            logic sr [STAGES];
            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                logic feed;
                if (i == 0) begin : g_head
                    assign feed = pulse_in;
                end else begin : g_link
                    assign feed = sr[i-1];
                end
                always_ff @(posedge clk) begin
                    if (clr) sr[i] <= 1'b0;
                    else     sr[i] <= feed;
                end
            end
            assign pulse_out = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned WIDTH     = 4,
    parameter int unsigned BT_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mr_i,
    input  logic             si_i,
    input  logic [WIDTH-1:0] din_i,
    output logic             ir_o,
    input  logic             so_i,
    output logic             or_o,
    output logic [WIDTH-1:0] dout_o,
    input  logic             oe_i,
    output logic             dout_en_o
);
    localparam int unsigned AW = addr_bits(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    logic       clr;
    strobe_ev_t si_ev, so_ev;
    wr_phase_e  wphase;
    rd_phase_e  rphase;
    logic       armed;
    logic       full;
    logic       wr_go, rd_go;
    logic       shown;
    logic       or_q, en_q;
    logic [CW-1:0]    occ, vis;
    logic [AW-1:0]    wptr, rptr;
    logic [WIDTH-1:0] rd_word, dout_q;

    assign clr = rst | mr_i;

    strobe_edge u_si_edge (.clk(clk), .clr(clr), .strobe(si_i), .ev(si_ev));
    strobe_edge u_so_edge (.clk(clk), .clr(clr), .strobe(so_i), .ev(so_ev));

    fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wptr),
        .wdata (din_i),
        .raddr (rptr),
        .rdata (rd_word)
    );

    bubble_delay #(.STAGES(BT_CYCLES)) u_bubble (
        .clk       (clk),
        .clr       (clr),
        .pulse_in  (wr_go),
        .pulse_out (shown)
    );

    // Write side handshake
    assign full  = (occ == FULL_CNT);
    assign ir_o  = (wphase == WR_OPEN) && !full;
    assign wr_go = ir_o && (si_ev.rise || (armed && si_ev.level));

    always_ff @(posedge clk) begin
        if (clr) begin
            wphase <= WR_OPEN;
            armed  <= 1'b0;
        end else begin
            case (wphase)
                WR_OPEN: begin
                    if (wr_go) begin
                        wphase <= WR_HOLD;
                        armed  <= 1'b0;
                    end else if (full && si_ev.level) begin
                        armed  <= 1'b1;
                    end else if (!si_ev.level) begin
                        armed  <= 1'b0;
                    end
                end
                WR_HOLD: begin
                    if (!si_ev.level) wphase <= WR_OPEN;
                end
                default: wphase <= WR_OPEN;
            endcase
        end
    end

    // Pointers, occupancy and visible-word count
    assign rd_go = or_q && so_ev.rise;

    always_ff @(posedge clk) begin
        if (clr) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
            vis  <= '0;
        end else begin
            if (wr_go) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
            if (rd_go) rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
            occ <= occ + CW'(wr_go) - CW'(rd_go);
            vis <= vis + CW'(shown) - CW'(rd_go);
        end
    end

    // Read side handshake and output register
    always_ff @(posedge clk) begin
        if (clr) begin
            rphase <= RD_OPEN;
            or_q   <= 1'b0;
            dout_q <= '0;
        end else begin
            case (rphase)
                RD_OPEN: begin
                    if (rd_go) begin
                        or_q   <= 1'b0;
                        rphase <= RD_HOLD;
                    end else if (!or_q && (vis != '0) && !so_ev.level) begin
                        or_q   <= 1'b1;
                        dout_q <= rd_word;
                    end
                end
                RD_HOLD: begin
                    if (!so_ev.level) rphase <= RD_OPEN;
                end
                default: rphase <= RD_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= ~oe_i;
    end

    assign or_o      = or_q;
    assign dout_o    = dout_q;
    assign dout_en_o = en_q;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             mr_i,
    input logic             si_i,
    input logic             ir_o,
    input logic             so_i,
    input logic             or_o,
    input logic [WIDTH-1:0] dout_o,
    input logic             oe_i,
    input logic             dout_en_o
);
    // R1
    ir_drop_chk: assert property (@(posedge clk) disable iff (rst || mr_i)
        (si_i && !$past(si_i) && ir_o) |=> !ir_o);

    // R2
    or_drop_chk: assert property (@(posedge clk) disable iff (rst || mr_i)
        (so_i && !$past(so_i) && or_o) |=> !or_o);

    // R2
    or_wait_low_chk: assert property (@(posedge clk) disable iff (rst || mr_i)
        (!or_o && so_i) |=> !or_o);

    // R4
    dout_stable_chk: assert property (@(posedge clk) disable iff (rst || mr_i)
        (!$rose(or_o) && !$past(mr_i) && !$past(rst)) |-> $stable(dout_o));

    // R5
    clear_state_chk: assert property (@(posedge clk) disable iff (rst)
        mr_i |=> (ir_o && !or_o && (dout_o == '0)));

    // R9
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        oe_i |=> !dout_en_o);

    // R9
    oe_on_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_i |=> dout_en_o);
endmodule

bind strobe_fifo strobe_fifo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mr_i      (mr_i),
    .si_i      (si_i),
    .ir_o      (ir_o),
    .so_i      (so_i),
    .or_o      (or_o),
    .dout_o    (dout_o),
    .oe_i      (oe_i),
    .dout_en_o (dout_en_o)
);

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;
    localparam int DEPTH = 64;
    localparam int WIDTH = 4;
    localparam int BT    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mr = 1'b0, si = 1'b0, so = 1'b0, oe = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic ir, orr, den;
    logic [WIDTH-1:0] dout;

    int ntests = 0;
    int nfail  = 0;
    int occ_m  = 0;
    logic [WIDTH-1:0] sb [$];
    logic so_prev = 1'b0;

    always #5 clk = ~clk;

    strobe_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BT_CYCLES(BT)) dut (
        .clk(clk), .rst(rst), .mr_i(mr), .si_i(si), .din_i(din), .ir_o(ir),
        .so_i(so), .or_o(orr), .dout_o(dout), .oe_i(oe), .dout_en_o(den)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every accepted read strobe (R4 order)
    always @(posedge clk) begin
        if (!rst && so && !so_prev && orr) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R4 read with empty scoreboard", int'(dout), 0);
            end else begin
                logic [WIDTH-1:0] e;
                e = sb.pop_front();
                chk(dout == e, "R4 order", int'(dout), int'(e));
            end
        end
        so_prev = so;
    end

    task automatic wait_ir();
        for (int i = 0; i < 200 && !ir; i++) @(negedge clk);
    endtask

    task automatic wait_or();
        for (int i = 0; i < 200 && !orr; i++) @(negedge clk);
    endtask

    // Driver: one complete write handshake
    task automatic push(input logic [WIDTH-1:0] d);
        wait_ir();
        din = d;
        si  = 1'b1;
        sb.push_back(d);
        occ_m++;
        @(negedge clk);
        chk(ir == 1'b0, "R1 ir drop", int'(ir), 0);
        @(negedge clk);
        chk(ir == 1'b0, "R1 ir held low", int'(ir), 0);
        si = 1'b0;
        @(negedge clk);
        chk(ir == (occ_m < DEPTH), "R1/R10 ir return", int'(ir), int'(occ_m < DEPTH));
    endtask

    // One complete read handshake
    task automatic pop();
        logic [WIDTH-1:0] v;
        wait_or();
        chk(orr == 1'b1, "R2 word ready", int'(orr), 1);
        v  = dout;
        so = 1'b1;
        @(negedge clk);
        chk(orr == 1'b0, "R2 or drop", int'(orr), 0);
        chk(dout == v, "R4 hold", int'(dout), int'(v));
        @(negedge clk);
        chk(orr == 1'b0, "R2 or held low", int'(orr), 0);
        chk(dout == v, "R4 hold", int'(dout), int'(v));
        so = 1'b0;
        occ_m--;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ir == 1'b1, "R5 reset ir", int'(ir), 1);
        chk(orr == 1'b0, "R5 reset or", int'(orr), 0);
        chk(dout == '0, "R6 reset dout", int'(dout), 0);

        // R9 output enable
        oe = 1'b1;
        @(negedge clk);
        chk(den == 1'b0, "R9 disable", int'(den), 0);
        oe = 1'b0;
        @(negedge clk);
        chk(den == 1'b1, "R9 enable", int'(den), 1);

        // R6: read strobe on an empty buffer is ignored
        so = 1'b1;
        @(negedge clk);
        so = 1'b0;
        repeat (3) @(negedge clk);
        chk(orr == 1'b0, "R6 empty strobe or", int'(orr), 0);
        chk(dout == '0, "R6 empty strobe dout", int'(dout), 0);
        chk(ir == 1'b1, "R6 empty strobe ir", int'(ir), 1);

        // R7 bubble-through latency
        din = 4'h5;
        si  = 1'b1;
        sb.push_back(4'h5);
        occ_m++;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            n++;
            if (orr) break;
            chk(dout == '0, "R6 zero before first word", int'(dout), 0);
        end
        chk(n == BT + 2, "R7 latency", n, BT + 2);
        si = 1'b0;
        @(negedge clk);
        pop();

        // several patterns, interleaved
        push(4'hA); push(4'h3);
        pop();
        push(4'hC);
        pop(); pop();
        for (int i = 0; i < 6; i++) push(WIDTH'(i * 3 + 1));
        for (int i = 0; i < 6; i++) pop();

        // fill to DEPTH (R10)
        for (int i = 0; i < DEPTH; i++) push(WIDTH'(i ^ 9));
        repeat (2) @(negedge clk);
        chk(ir == 1'b0, "R10 full ir", int'(ir), 0);

        // R3: strobe while full, released before space frees
        din = 4'hF;
        si  = 1'b1;
        repeat (3) @(negedge clk);
        chk(ir == 1'b0, "R3 full ignores strobe", int'(ir), 0);
        si = 1'b0;
        repeat (2) @(negedge clk);

        // R8: strobe held while full, one read frees a slot
        din = 4'h6;
        si  = 1'b1;
        repeat (2) @(negedge clk);
        wait_or();
        so = 1'b1;
        @(negedge clk);
        chk(ir == 1'b1, "R8 ir pulse high", int'(ir), 1);
        sb.push_back(4'h6);
        @(negedge clk);
        chk(ir == 1'b0, "R8 ir pulse ends", int'(ir), 0);
        so = 1'b0;
        si = 1'b0;
        @(negedge clk);

        // drain everything (R3: no extra word)
        for (int i = 0; i < DEPTH; i++) pop();
        repeat (BT + 4) @(negedge clk);
        chk(orr == 1'b0, "R3 drained or", int'(orr), 0);
        chk(sb.size() == 0, "R3 scoreboard empty", sb.size(), 0);
        chk(ir == 1'b1, "R3 drained ir", int'(ir), 1);

        // R5 master clear
        occ_m = 0;
        push(4'h1); push(4'h2); push(4'h4);
        repeat (BT + 3) @(negedge clk);
        mr = 1'b1;
        @(negedge clk);
        mr = 1'b0;
        chk(ir == 1'b1, "R5 clear ir", int'(ir), 1);
        chk(orr == 1'b0, "R5 clear or", int'(orr), 0);
        chk(dout == '0, "R5 clear dout", int'(dout), 0);
        sb.delete();
        occ_m = 0;
        repeat (BT + 3) @(negedge clk);
        chk(orr == 1'b0, "R5 contents discarded", int'(orr), 0);
        push(4'h9);
        pop();
        chk(sb.size() == 0, "R5 post-clear order", sb.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule